// File: doc/BRIEF.md
# Received Audio Sample Formatter

This block sits behind a line decoder that has already recovered subframes from a two-channel digital audio stream. For each subframe it is given the preamble kind, the 24-bit audio field and the four trailing flag bits: validity, user, channel-status and parity. A nine-bit mode register decides which subframes are accepted. It also sets how the audio field is trimmed to the requested sample width, and the byte order of the resulting 32-bit word. Accepted words land in a single holding register, which a consumer reads with a one-cycle strobe.

Three sticky indications are reported on a status vector: a sample is waiting, a parity failure was seen, and a sample was lost because a newer one replaced it before it was read. A software-reset strobe returns the holding register and all indications to idle. The mode register keeps its contents through that reset. The preamble kind is coded 2'b00 for the block-start subframe, 2'b01 for the first channel and 2'b10 for the second. The code 2'b11 is treated as an ordinary subframe.

Top module: `spdif_sample_fmt`

## Requirements
- R1: Mode bit 0 is receive enable. While it is 0, no subframe changes the holding register or the ready flag, and no parity failure is recorded.
- R2: Mode bit 1 selects validity handling. With it 0, every subframe is loaded. With it 1, a subframe whose validity bit is 1 is dropped.
- R3: Mode bit 8 selects block-start handling. With it 1, a subframe whose preamble kind is 2'b00 is dropped. With it 0, that subframe is loaded like any other.
- R4: Mode bits 5:4 hold the width code, which equals 6 minus width/4. Code 0 means 24 bits, 1 means 20 bits and 2 means 16 bits; code 3 behaves as 24 bits. The most significant width bits of the audio field become the sample, sign-extended to 32 bits.
- R5: Mode bit 2 selects byte order. With it 0, the word is stored with bit 31 as the sign end. With it 1, the four bytes of that word are stored in reverse order.
- R6: Parity is even over audio, V, U, C and P (time slots 4 to 31). If mode bit 3 is 0, a failing enabled subframe sets the sticky parity-error flag at status bit 5, whether or not the sample is loaded. If mode bit 3 is 1, the check is skipped.
- R7: A load updates the holding register and sets the ready flag at status bit 0, both visible after the clock edge that samples the subframe. A read strobe without a load clears ready at the next edge.
- R8: A load that arrives while ready is set, without a read strobe in the same cycle, sets the sticky overrun flag at status bit 6. The new sample replaces the old one.
- R9: The software-reset strobe clears the holding register and all three flags at the next edge. It takes priority over a load in the same cycle, and the mode register is unaffected.
- R10: A read strobe and a load in the same cycle leave ready set, hold the new sample, and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_valid | input | 1 | A decoded subframe is presented this cycle |
| sf_kind | input | 2 | Preamble kind: 00 block start, 01 first channel, 10 second channel |
| sf_audio | input | 24 | Audio field, bit 23 most significant |
| sf_v | input | 1 | Validity bit |
| sf_u | input | 1 | User bit |
| sf_c | input | 1 | Channel-status bit |
| sf_p | input | 1 | Parity bit |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 9 | New mode register value |
| soft_rst | input | 1 | Software-reset command strobe |
| rd_strobe | input | 1 | Holding register read strobe |
| rd_data | output | 32 | Holding register contents |
| status | output | 7 | Bit 0 ready, bit 5 parity error, bit 6 overrun, others 0 |

## Verification
The bench builds the block with its default 24-bit audio field and 32-bit word. This brings all three width codes, the sign extension from each, and all four byte lanes of the reversed order within reach, using negative as well as positive samples. A behavioural model computes each expected word by arithmetic shifting and per-byte reordering. It is compared on every cycle across accept and drop combinations, sticky flags, simultaneous read and load, and a software reset that collides with a load.

// File: rtl/spdif_sample_fmt.sv
module spdif_sample_fmt #(
  parameter int AUD_W  = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_valid,
  input  logic [1:0]        sf_kind,
  input  logic [AUD_W-1:0]  sf_audio,
  input  logic              sf_v,
  input  logic              sf_u,
  input  logic              sf_c,
  input  logic              sf_p,
  input  logic              mode_we,
  input  logic [8:0]        mode_wdata,
  input  logic              soft_rst,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rd_data,
  output logic [6:0]        status
);
  localparam int NBYTES = WORD_W / 8;
  localparam int EXT24  = WORD_W - AUD_W;
  localparam int EXT20  = WORD_W - AUD_W + 4;
  localparam int EXT16  = WORD_W - AUD_W + 8;
  localparam logic [1:0] KIND_BLOCK = 2'b00;

  logic [8:0]        mode_q;
  logic [WORD_W-1:0] hold_q;
  logic              ready_q, perr_q, ovr_q;

  logic              m_en, m_vdrop, m_big, m_nopar, m_bdrop;
  logic [1:0]        m_wcode;
  assign m_en    = mode_q[0];
  assign m_vdrop = mode_q[1];
  assign m_big   = mode_q[2];
  assign m_nopar = mode_q[3];
  assign m_wcode = mode_q[5:4];
  assign m_bdrop = mode_q[8];

  logic [WORD_W-1:0] w24, w20, w16, narrow, swapped, word;
  assign w24 = {{EXT24{sf_audio[AUD_W-1]}}, sf_audio};
  assign w20 = {{EXT20{sf_audio[AUD_W-1]}}, sf_audio[AUD_W-1:4]};
  assign w16 = {{EXT16{sf_audio[AUD_W-1]}}, sf_audio[AUD_W-1:8]};

  always_comb begin
    case (m_wcode)
      2'd1:    narrow = w20;
      2'd2:    narrow = w16;
      default: narrow = w24;
    endcase
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = narrow[8*(NBYTES-1-b) +: 8];
  end

  assign word = m_big ? swapped : narrow;

  logic par_bad, keep, load, par_hit;
  assign par_bad = ^{sf_audio, sf_v, sf_u, sf_c, sf_p};
  assign keep    = m_en && !(m_vdrop && sf_v) && !(m_bdrop && sf_kind == KIND_BLOCK);
  assign load    = sf_valid && keep;
  assign par_hit = sf_valid && m_en && !m_nopar && par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      hold_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (soft_rst) begin
        hold_q  <= '0;
        ready_q <= 1'b0;
        perr_q  <= 1'b0;
        ovr_q   <= 1'b0;
      end else begin
        if (load) hold_q <= word;
        if (load) ready_q <= 1'b1;
        else if (rd_strobe) ready_q <= 1'b0;
        if (load && ready_q && !rd_strobe) ovr_q <= 1'b1;
        if (par_hit) perr_q <= 1'b1;
      end
    end
  end

  assign rd_data = hold_q;
  assign status  = {ovr_q, perr_q, 4'b0000, ready_q};

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_en && !soft_rst) |=> ($stable(hold_q) && $stable(ready_q) && $stable(perr_q)));

  p_vbit_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_valid && m_vdrop && sf_v && !soft_rst && !rd_strobe) |=> ($stable(hold_q) && $stable(ready_q)));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !load && !soft_rst) |=> !status[0]);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready_q && !rd_strobe && !soft_rst) |=> status[6]);

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == 7'd0 && rd_data == '0));

  p_perr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q && !soft_rst) |=> perr_q);

  p_both_keeps_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rd_strobe && !soft_rst) |=> (status[0] && $stable(ovr_q)));
endmodule

// File: tb/spdif_sample_fmt_tb.sv
module spdif_sample_fmt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sf_valid = 1'b0;
  logic [1:0]  sf_kind = 2'b01;
  logic [23:0] sf_audio = '0;
  logic        sf_v = 1'b0, sf_u = 1'b0, sf_c = 1'b0, sf_p = 1'b0;
  logic        mode_we = 1'b0;
  logic [8:0]  mode_wdata = '0;
  logic        soft_rst = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [31:0] rd_data;
  logic [6:0]  status;

  always #2 clk = ~clk;

  spdif_sample_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_kind(sf_kind),
    .sf_audio(sf_audio), .sf_v(sf_v), .sf_u(sf_u), .sf_c(sf_c), .sf_p(sf_p),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .soft_rst(soft_rst),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .status(status)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R9";
  bit    done = 1'b0;

  logic [8:0]  m_mode = '0;
  logic [31:0] e_data = '0;
  bit          e_rdy = 0, e_perr = 0, e_ovr = 0;

  function automatic logic [31:0] expect_word(logic [23:0] a, logic [8:0] md);
    int w;
    logic signed [31:0] t;
    logic [31:0] r;
    w = (md[5:4] == 2'd1) ? 20 : (md[5:4] == 2'd2) ? 16 : 24;
    t = $signed({a, 8'h00}) >>> (32 - w);
    r = t;
    if (md[2]) begin
      for (int k = 0; k < 4; k++) r[8*k +: 8] = t[8*(3-k) +: 8];
    end
    return r;
  endfunction

  task automatic model_step();
    bit drop, ld, pe;
    drop = (m_mode[1] && sf_v) || (m_mode[8] && sf_kind == 2'b00);
    ld = sf_valid && m_mode[0] && !drop;
    pe = sf_valid && m_mode[0] && !m_mode[3] &&
         ($countones({sf_audio, sf_v, sf_u, sf_c, sf_p}) % 2 == 1);
    if (soft_rst) begin
      e_data = '0; e_rdy = 0; e_perr = 0; e_ovr = 0;
    end else begin
      if (ld) begin
        if (e_rdy && !rd_strobe) e_ovr = 1;
        e_data = expect_word(sf_audio, m_mode);
        e_rdy = 1;
      end else if (rd_strobe) e_rdy = 0;
      if (pe) e_perr = 1;
    end
    if (mode_we) m_mode = mode_wdata;
  endtask

  task automatic compare();
    logic [6:0] es;
    es = {e_ovr, e_perr, 4'b0000, e_rdy};
    checks++;
    if (rd_data !== e_data) begin
      errors++;
      $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, e_data);
    end
    checks++;
    if (status !== es) begin
      errors++;
      $display("FAIL %s status actual=%b expected=%b", cur_req, status, es);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    sf_valid = 0; sf_v = 0; sf_u = 0; sf_c = 0; sf_p = 0; sf_kind = 2'b01;
    mode_we = 0; soft_rst = 0; rd_strobe = 0;
  endtask

  task automatic set_mode(logic [8:0] m);
    mode_we = 1; mode_wdata = m;
    cycle();
  endtask

  task automatic send(logic [1:0] kind, logic [23:0] a, bit v, bit bad, bit rd);
    sf_valid = 1; sf_kind = kind; sf_audio = a; sf_v = v;
    sf_u = a[3]; sf_c = a[7];
    sf_p = (($countones({a, v, a[3], a[7]}) % 2) == 1) ^ bad;
    rd_strobe = rd;
    cycle();
  endtask

  task automatic rd();
    rd_strobe = 1;
    cycle();
  endtask

  task automatic srst();
    soft_rst = 1;
    cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R9";
    compare();

    cur_req = "R1";
    send(2'b01, 24'h123456, 0, 0, 0);
    send(2'b10, 24'h800001, 0, 1, 0);

    cur_req = "R7";
    set_mode(9'h001);
    send(2'b01, 24'h123456, 0, 0, 0);
    rd();
    cycle();

    cur_req = "R4";
    send(2'b01, 24'h876543, 0, 0, 1);
    set_mode(9'h011);
    send(2'b10, 24'hF12345, 0, 0, 1);
    send(2'b10, 24'h7ABCDE, 0, 0, 1);
    set_mode(9'h021);
    send(2'b01, 24'h9ABCDE, 0, 0, 1);
    send(2'b01, 24'h4ABCDE, 0, 0, 1);
    set_mode(9'h031);
    send(2'b01, 24'hC00003, 0, 0, 1);

    cur_req = "R5";
    set_mode(9'h005);
    send(2'b01, 24'h123456, 0, 0, 1);
    send(2'b01, 24'hA1B2C3, 0, 0, 1);
    set_mode(9'h025);
    send(2'b10, 24'h8899AA, 0, 0, 1);
    rd();

    cur_req = "R2";
    set_mode(9'h001);
    send(2'b01, 24'h0F0F0F, 1, 0, 0);
    rd();
    set_mode(9'h003);
    send(2'b01, 24'h111111, 1, 0, 0);
    send(2'b01, 24'h222222, 0, 0, 0);
    rd();

    cur_req = "R3";
    set_mode(9'h001);
    send(2'b00, 24'h333333, 0, 0, 1);
    rd();
    set_mode(9'h101);
    send(2'b00, 24'h444444, 0, 0, 0);
    send(2'b11, 24'h555555, 0, 0, 0);
    rd();

    cur_req = "R6";
    set_mode(9'h009);
    send(2'b01, 24'h666666, 0, 1, 1);
    rd();
    set_mode(9'h001);
    send(2'b01, 24'h777777, 0, 0, 1);
    rd();
    set_mode(9'h103);
    send(2'b00, 24'h010101, 0, 1, 0);
    cycle();
    send(2'b01, 24'h020202, 0, 0, 0);
    rd();

    cur_req = "R9";
    srst();

    cur_req = "R1";
    set_mode(9'h000);
    send(2'b01, 24'h030303, 0, 1, 0);

    cur_req = "R8";
    set_mode(9'h001);
    send(2'b01, 24'h100000, 0, 0, 0);
    send(2'b10, 24'h200000, 0, 0, 0);
    send(2'b01, 24'h300000, 0, 0, 0);
    rd();

    cur_req = "R10";
    srst();
    send(2'b01, 24'h400000, 0, 0, 0);
    send(2'b10, 24'h500000, 0, 0, 1);
    rd();

    cur_req = "R9";
    send(2'b01, 24'h600000, 0, 1, 0);
    sf_valid = 1; sf_kind = 2'b01; sf_audio = 24'h700000; soft_rst = 1;
    sf_p = 1;
    cycle();
    send(2'b01, 24'h800000, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule